// File: doc/BRIEF.md
# Peripheral Interrupt Routing Controller

This block gathers sixty-four level-sensitive interrupt requests from peripherals and steers each one to one of seven core priority lines. Every source has a 4-bit assignment code. Code n drives core line n, which the core event controller treats as priority level 7+n. Line 0 is level 7 and line 6 is level 13. The core-side latching, nesting and vectoring are done elsewhere. Any edge detection is done inside the peripherals.

Software controls the block through a small word-wide register bus. Writes take effect at the clock edge where `bus_we` is sampled high. A read returns its data one cycle after `bus_re` is sampled high. The bus is a control path with no flow control: every access completes in a fixed cycle, so it has no valid/ready handshake. The requests pass through one register stage. The core lines and the wakeup flag are registered outputs.

Register word map (4-bit word address):

| Address | Content |
|---|---|
| 0 | mask, sources 0–31 |
| 1 | mask, sources 32–63 |
| 2 | raw status, sources 0–31 |
| 3 | raw status, sources 32–63 |
| 4 | wakeup enable, sources 0–31 |
| 5 | wakeup enable, sources 32–63 |
| 8–15 | assignment codes |

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, all mask bits and all wakeup-enable bits are 0, and `core_lvl` and `wake_o` are low. Assignment codes reset as follows: sources 26–31 to 4, 32–41 to 5, 42–46 to 6, 47–50 to 0, 51–55 to 3, and every other source to 0.
- R2: Mask word 0 (address 0) and wakeup word 0 (address 4) hold source k in bit k, for sources 0–31. Mask word 1 (address 1) and wakeup word 1 (address 5) hold source k in bit k−32, for sources 32–63. A write to one of these addresses is read back unchanged.
- R3: A source whose mask bit is 0 has no effect on any `core_lvl` bit.
- R4: Addresses 2 and 3 return the registered raw request of each source, using the same bit positions as the mask words, whatever the mask holds. Writes to these addresses change nothing.
- R5: `core_lvl[n]` is high exactly when at least one requesting, unmasked source holds assignment code n, for n = 0 to 6. The line rises two cycles after the request or the register write that causes it.
- R6: Assignment register j sits at address 8+j. Source k uses bits [4*(k mod 8)+3 : 4*(k mod 8)] of register floor(k/8). The register is readable and writable.
- R7: A source holding a code from 7 to 15 drives no `core_lvl` bit.
- R8: `wake_o` is high when at least one requesting source has its wakeup-enable bit set, whatever the mask holds. Its timing matches `core_lvl`.
- R9: `bus_rdata` carries the addressed word on the cycle after `bus_re`. Addresses 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Level request per peripheral source |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_re` |
| core_lvl | output | 7 | One request line per core priority level 7–13 |
| wake_o | output | 1 | Wakeup indication |

## Verification
A request change, or a write to a mask, wakeup or assignment register, first shows on `core_lvl` and `wake_o` two cycles later. Read data appears one cycle after the read strobe. The driver updates a reference model at each negative edge and queues the expected result for cycle +2 (outputs) or cycle +1 (reads). The monitor samples 5 ns after each rising edge and compares only the items whose due cycle has arrived. Reads are never issued in the same cycle as a request change, so the status value expected is always settled.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SRC_N       = 64;
  localparam int WORD_W      = 32;
  localparam int CODE_W      = 4;
  localparam int LVL_N       = 7;
  localparam int ADDR_W      = 4;
  localparam int SRC_WORDS   = SRC_N / WORD_W;
  localparam int FIELDS_PER  = WORD_W / CODE_W;
  localparam int ASSIGN_REGS = SRC_N / FIELDS_PER;
  localparam int ADDR_MASK   = 0;
  localparam int ADDR_STAT   = ADDR_MASK + SRC_WORDS;
  localparam int ADDR_WAKE   = ADDR_STAT + SRC_WORDS;
  localparam int ADDR_ASSIGN = 8;

  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t reset_code(int k);
    if (k >= 26 && k <= 31) return code_t'(4);
    if (k >= 32 && k <= 41) return code_t'(5);
    if (k >= 42 && k <= 46) return code_t'(6);
    if (k >= 51 && k <= 55) return code_t'(3);
    return code_t'(0);
  endfunction
endpackage

// File: rtl/irq_route_sample.sv
module irq_route_sample #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [SRC_N-1:0]   stat_i,
  output logic [SRC_N-1:0]   mask_o,
  output logic [SRC_N-1:0]   wake_o,
  output code_t              code_o [SRC_N]
);
  logic [SRC_N-1:0]  mask_q, wake_q;
  code_t             code_q [SRC_N];
  logic [WORD_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      wake_q <= '0;
      for (int k = 0; k < SRC_N; k++) code_q[k] <= reset_code(k);
    end else if (bus_we) begin
      for (int w = 0; w < SRC_WORDS; w++) begin
        if (bus_addr == ADDR_W'(ADDR_MASK + w)) mask_q[w*WORD_W +: WORD_W] <= bus_wdata;
        if (bus_addr == ADDR_W'(ADDR_WAKE + w)) wake_q[w*WORD_W +: WORD_W] <= bus_wdata;
      end
      for (int r = 0; r < ASSIGN_REGS; r++) begin
        if (bus_addr == ADDR_W'(ADDR_ASSIGN + r)) begin
          for (int f = 0; f < FIELDS_PER; f++)
            code_q[r*FIELDS_PER + f] <= bus_wdata[f*CODE_W +: CODE_W];
        end
      end
    end
  end

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < SRC_WORDS; w++) begin
      if (bus_addr == ADDR_W'(ADDR_MASK + w)) rd_d = mask_q[w*WORD_W +: WORD_W];
      if (bus_addr == ADDR_W'(ADDR_STAT + w)) rd_d = stat_i[w*WORD_W +: WORD_W];
      if (bus_addr == ADDR_W'(ADDR_WAKE + w)) rd_d = wake_q[w*WORD_W +: WORD_W];
    end
    for (int r = 0; r < ASSIGN_REGS; r++) begin
      if (bus_addr == ADDR_W'(ADDR_ASSIGN + r)) begin
        for (int f = 0; f < FIELDS_PER; f++)
          rd_d[f*CODE_W +: CODE_W] = code_q[r*FIELDS_PER + f];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_d;
  end

  assign mask_o = mask_q;
  assign wake_o = wake_q;
  always_comb for (int k = 0; k < SRC_N; k++) code_o[k] = code_q[k];

  // R2: a write to mask word 0 lands in the low mask bits
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_MASK)) |=> (mask_q[WORD_W-1:0] == $past(bus_wdata)));

  // R4: a status-address write leaves every writable register alone
  assert_stat_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_STAT)) |=> ($stable(mask_q) && $stable(wake_q)));
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  req_q,
  input  logic [SRC_N-1:0]  mask_i,
  input  logic [SRC_N-1:0]  wake_en_i,
  input  code_t             code_i [SRC_N],
  output logic [LVL_N-1:0]  lvl_o,
  output logic              wake_o
);
  logic [LVL_N-1:0] lvl_d;
  logic [SRC_N-1:0] live;

  assign live = req_q & mask_i;

  for (genvar lv = 0; lv < LVL_N; lv++) begin : g_lvl
    always_comb begin
      lvl_d[lv] = 1'b0;
      for (int k = 0; k < SRC_N; k++)
        if (live[k] && code_i[k] == CODE_W'(lv)) lvl_d[lv] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      lvl_o  <= lvl_d;
      wake_o <= |(req_q & wake_en_i);
    end
  end

  // R3: with every source masked, no core line rises
  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> (lvl_o == '0));

  // R5: no request, no core line
  assert_idle_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0) |=> (lvl_o == '0));

  // R8: wakeup only follows an enabled request
  assert_wake_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & wake_en_i) == '0) |=> !wake_o);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_N-1:0]   irq_req,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic [LVL_N-1:0]   core_lvl,
  output logic               wake_o
);
  logic [SRC_N-1:0] req_q, mask, wake_en;
  code_t            codes [SRC_N];

  irq_route_sample #(.N(SRC_N)) u_sample (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req), .req_q(req_q)
  );

  irq_route_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stat_i(req_q), .mask_o(mask), .wake_o(wake_en), .code_o(codes)
  );

  irq_route_map u_map (
    .clk(clk), .rst_n(rst_n), .req_q(req_q), .mask_i(mask),
    .wake_en_i(wake_en), .code_i(codes), .lvl_o(core_lvl), .wake_o(wake_o)
  );

  // R1: outputs are low on the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (core_lvl == '0 && !wake_o));
endmodule

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_req = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  core_lvl;
  logic        wake_o;

  irq_route_ctrl uut (.*);

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    bit          is_rd;
    logic [31:0] data;
    logic [6:0]  lvl;
    logic        wake;
    string       tag;
  } item_t;

  item_t       q[$];
  int          cyc = 0;
  int          checks = 0, fails = 0;
  bit          done = 0;
  logic [63:0] m_mask = '0, m_wake = '0, m_req = '0;
  logic [3:0]  m_code [64];

  function automatic logic [3:0] def_code(int k);
    if (k >= 26 && k <= 31) return 4'd4;
    if (k >= 32 && k <= 41) return 4'd5;
    if (k >= 42 && k <= 46) return 4'd6;
    if (k >= 47 && k <= 50) return 4'd0;
    if (k >= 51 && k <= 55) return 4'd3;
    return 4'd0;
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] d = '0;
    case (a)
      0: d = m_mask[31:0];
      1: d = m_mask[63:32];
      2: d = m_req[31:0];
      3: d = m_req[63:32];
      4: d = m_wake[31:0];
      5: d = m_wake[63:32];
      default: if (a >= 8) for (int f = 0; f < 8; f++) d[4*f +: 4] = m_code[(a-8)*8 + f];
    endcase
    return d;
  endfunction

  task automatic push_out(string tag);
    item_t it;
    logic [6:0] l = '0;
    for (int k = 0; k < 64; k++)
      if (m_req[k] && m_mask[k] && m_code[k] < 4'd7) l[m_code[k]] = 1'b1;
    it.due = cyc + 2; it.is_rd = 0; it.data = '0; it.lvl = l;
    it.wake = |(m_req & m_wake); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    bus_we = 0; bus_re = 0;
  endtask

  task automatic do_write(int a, logic [31:0] d, string tag);
    tick();
    bus_we = 1; bus_addr = 4'(a); bus_wdata = d;
    case (a)
      0: m_mask[31:0] = d;
      1: m_mask[63:32] = d;
      4: m_wake[31:0] = d;
      5: m_wake[63:32] = d;
      default: if (a >= 8) for (int f = 0; f < 8; f++) m_code[(a-8)*8 + f] = d[4*f +: 4];
    endcase
    push_out(tag);
  endtask

  task automatic do_read(int a, string tag);
    item_t it;
    tick();
    bus_re = 1; bus_addr = 4'(a);
    it.due = cyc + 1; it.is_rd = 1; it.data = model_read(a);
    it.lvl = '0; it.wake = 0; it.tag = tag;
    q.push_back(it);
    push_out(tag);
  endtask

  task automatic set_req(logic [63:0] v, string tag);
    tick();
    irq_req = v; m_req = v;
    push_out(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin tick(); push_out(tag); end
  endtask

  // monitor: compares queued expectations on their due cycle
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      while (q.size() > 0 && q[0].due <= cyc) begin
        it = q.pop_front();
        checks++;
        if (it.is_rd) begin
          if (bus_rdata !== it.data) begin
            fails++;
            $display("FAIL %s rdata actual=%h expected=%h (cycle %0d)", it.tag, bus_rdata, it.data, cyc);
          end
        end else if (core_lvl !== it.lvl || wake_o !== it.wake) begin
          fails++;
          $display("FAIL %s lvl/wake actual=%b/%b expected=%b/%b (cycle %0d)",
                   it.tag, core_lvl, wake_o, it.lvl, it.wake, cyc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) m_code[k] = def_code(k);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state of every register and output
    for (int a = 0; a < 16; a++) do_read(a, "R1");
    idle(2, "R1");

    // R2: unmask all sources, read back
    do_write(0, 32'hFFFF_FFFF, "R2");
    do_write(1, 32'hFFFF_FFFF, "R2");
    do_read(0, "R2");
    do_read(1, "R2");

    // R5: default routes to each level
    set_req(64'd1 << 30, "R5");
    idle(2, "R5");
    set_req(64'd1 << 35, "R5");
    idle(2, "R5");
    set_req((64'd1 << 44) | (64'd1 << 48), "R5");
    idle(2, "R5");
    set_req((64'd1 << 53) | (64'd1 << 27) | (64'd1 << 10), "R5");
    idle(2, "R5");

    // R3: clear mask bit of source 48 (word 1 bit 16) while it requests
    set_req(64'd1 << 48, "R3");
    idle(2, "R3");
    do_write(1, 32'hFFFE_FFFF, "R3");
    idle(2, "R3");

    // R4: status shows raw request regardless of mask; writes ignored
    do_write(0, 32'h0000_0000, "R4");
    set_req(64'hA5A5_0000_0000_5A5A, "R4");
    idle(1, "R4");
    do_read(2, "R4");
    do_read(3, "R4");
    do_write(2, 32'h1234_5678, "R4");
    do_write(3, 32'h8765_4321, "R4");
    do_read(0, "R4");
    do_read(1, "R4");
    do_read(2, "R4");

    // R6: reprogram codes in assignment register 0
    do_write(0, 32'hFFFF_FFFF, "R6");
    do_write(8, 32'hF070_2001, "R6");
    do_read(8, "R6");
    set_req(64'd1 << 0, "R6");
    idle(2, "R6");
    set_req(64'd1 << 3, "R6");
    idle(2, "R6");
    // R7: source 5 holds code 7, source 7 holds code 15
    set_req((64'd1 << 5) | (64'd1 << 7), "R7");
    idle(2, "R7");
    do_write(15, 32'h9999_9999, "R7");
    set_req(64'hFF00_0000_0000_0000, "R7");
    idle(2, "R7");
    do_read(15, "R7");

    // R8: wakeup independent of mask
    do_write(0, 32'h0, "R8");
    do_write(1, 32'h0, "R8");
    do_write(4, 32'h0000_0008, "R8");
    set_req(64'd1 << 3, "R8");
    idle(2, "R8");
    set_req(64'd1 << 4, "R8");
    idle(2, "R8");
    do_write(5, 32'h8000_0000, "R8");
    set_req(64'd1 << 63, "R8");
    idle(2, "R8");
    do_read(5, "R8");

    // R9: unmapped addresses
    do_write(6, 32'hDEAD_BEEF, "R9");
    do_write(7, 32'hCAFE_F00D, "R9");
    do_read(6, "R9");
    do_read(7, "R9");
    do_read(4, "R9");

    idle(4, "R5");
    while (q.size() > 0) @(posedge clk);
    #6;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule